// File: doc/BRIEF.md
# Burst Prefetch Read/Write Engine

This engine sits between a compute control path and the command side of a burst-capable memory master. It also drives one port of an on-chip dual-port buffer RAM. The control path asks for one transfer at a time. Each request carries a direction, a memory byte address, a byte length and a starting buffer location. The engine then deals with the memory handshake, so the control path never sees it.

For a read (prefetch), the engine raises a command and waits for the memory's read-ready acknowledgment. It then writes each incoming beat into the buffer RAM at consecutive locations. For a write, it waits for the write-ready acknowledgment. It then fetches each beat from the buffer RAM and hands it to the master. A transfer longer than one burst is split into back-to-back bursts. When the last beat has been taken, a one-cycle completion pulse tells the control path that the transfer is finished. The compute logic uses the second port of the buffer RAM, so it can work while prefetch traffic is running.

Top module: `burst_xfer_engine`

## Requirements
- R1: `req_ready` is high only while the engine is idle. A request is taken when `req_valid` and `req_ready` are both high. A `req_valid` raised while busy is ignored: it starts no command later.
- R2: `cmd_valid` stays high, with `cmd_addr` and `cmd_beats` stable, until the matching acknowledgment arrives (`mem_rd_rdy` for a read command, `mem_wr_rdy` for a write command). The other acknowledgment is ignored. No buffer access and no write beat happens while the command is pending. `cmd_write` is 1 for a write command and 0 for a read command.
- R3: In the read data phase, each cycle with `rd_beat_valid` high writes `rd_beat_data` into the buffer. The first beat goes to `req_buf_addr`, and each later beat goes one location higher, wrapping modulo 2^BUF_AW, across all bursts of the transfer.
- R4: A transfer moves ceil(`req_len`/4) beats of 4 bytes each. Each burst has min(remaining beats, 256) beats, reported in `cmd_beats`. The first burst uses `req_addr`. Each later burst's `cmd_addr` is the previous one plus 4 × the previous burst's beat count.
- R5: In the write data phase, beat k presents the buffer content at location (`req_buf_addr` + k) mod 2^BUF_AW on `wr_beat_data` with `wr_beat_valid` high. The beat stays unchanged until `wr_beat_ready` is seen.
- R6: `done` is high for exactly one cycle: the cycle after the final beat is accepted. For a zero-length request it is the cycle after acceptance, and no command is issued.
- R7: If the matching acknowledgment has not arrived after ACK_TIMEOUT cycles of `cmd_valid`, the command is dropped and the engine returns to idle without `done`. `ack_timeout` is then set and stays set until reset.
- R8: After reset, `req_ready` is 1 and `cmd_valid`, `done`, `ack_timeout` and `buf_en` are 0.
- R9: `rd_beat_valid` outside the read data phase writes nothing into the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Control path request strobe |
| req_write | input | 1 | 1 = buffer to memory, 0 = memory to buffer |
| req_addr | input | ADDR_W | Memory byte address of the transfer |
| req_len | input | LEN_W | Transfer length in bytes |
| req_buf_addr | input | BUF_AW | First buffer location |
| req_ready | output | 1 | Engine idle, request accepted |
| done | output | 1 | One-cycle completion pulse |
| ack_timeout | output | 1 | Sticky acknowledgment timeout flag |
| cmd_valid | output | 1 | Command pending to memory master |
| cmd_write | output | 1 | Command direction |
| cmd_addr | output | ADDR_W | Burst byte address |
| cmd_beats | output | BEAT_W | Burst beat count (1..MAX_BEATS) |
| mem_rd_rdy | input | 1 | Read-ready acknowledgment |
| mem_wr_rdy | input | 1 | Write-ready acknowledgment |
| rd_beat_valid | input | 1 | Incoming read beat strobe |
| rd_beat_data | input | DATA_W | Incoming read beat |
| rd_beat_ready | output | 1 | Engine in read data phase |
| wr_beat_valid | output | 1 | Outgoing write beat available |
| wr_beat_data | output | DATA_W | Outgoing write beat |
| wr_beat_ready | input | 1 | Master takes the write beat |
| buf_en | output | 1 | Buffer port enable |
| buf_we | output | 1 | Buffer port write enable |
| buf_addr | output | BUF_AW | Buffer port location |
| buf_wdata | output | DATA_W | Buffer write data |
| buf_rdata | input | DATA_W | Buffer read data, one cycle after a read enable |

## Verification
A corrupted buffer pointer shows up on the very next buffer write or write beat, because the location or data differs from the bench's own count from `req_buf_addr`. A wrong remaining-beat or burst count shows up when the next command appears: its `cmd_addr` or `cmd_beats` is wrong, or `done` arrives early or late. A stuck state machine surfaces within ACK_TIMEOUT cycles: `cmd_valid` lingers, `ack_timeout` changes, or a stray buffer write appears in a phase where none is expected.

// File: rtl/burst_xfer_engine.sv
module burst_xfer_engine #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BUF_AW      = 10,
  parameter int LEN_W       = 20,
  parameter int MAX_BEATS   = 256,
  parameter int ACK_TIMEOUT = 1024,
  localparam int BEAT_W     = $clog2(MAX_BEATS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BUF_AW-1:0] req_buf_addr,
  output logic              req_ready,
  output logic              done,
  output logic              ack_timeout,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BEAT_W-1:0] cmd_beats,
  input  logic              mem_rd_rdy,
  input  logic              mem_wr_rdy,
  input  logic              rd_beat_valid,
  input  logic [DATA_W-1:0] rd_beat_data,
  output logic              rd_beat_ready,
  output logic              wr_beat_valid,
  output logic [DATA_W-1:0] wr_beat_data,
  input  logic              wr_beat_ready,
  output logic              buf_en,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  input  logic [DATA_W-1:0] buf_rdata
);
  localparam int BYTES = DATA_W / 8;
  localparam int SHIFT = $clog2(BYTES);
  localparam int REM_W = LEN_W + 1;
  localparam int TMO_W = $clog2(ACK_TIMEOUT) + 1;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_RD, S_WFETCH, S_WSEND} st_t;

  st_t               st;
  logic              is_wr, done_q, tmo_flag;
  logic [ADDR_W-1:0] cur_addr;
  logic [REM_W-1:0]  rem;
  logic [BEAT_W-1:0] burst_left;
  logic [BUF_AW-1:0] bptr;
  logic [TMO_W-1:0]  tmo;

  wire [REM_W-1:0]  req_beats  = ({1'b0, req_len} + REM_W'(BYTES - 1)) >> SHIFT;
  wire [BEAT_W-1:0] burst_sz   = (rem > REM_W'(MAX_BEATS)) ? BEAT_W'(MAX_BEATS) : BEAT_W'(rem);
  wire              ack_match  = is_wr ? mem_wr_rdy : mem_rd_rdy;
  wire              beat_taken = (st == S_RD && rd_beat_valid) || (st == S_WSEND && wr_beat_ready);

  assign req_ready     = (st == S_IDLE);
  assign done          = done_q;
  assign ack_timeout   = tmo_flag;
  assign cmd_valid     = (st == S_CMD);
  assign cmd_write     = is_wr;
  assign cmd_addr      = cur_addr;
  assign cmd_beats     = burst_sz;
  assign rd_beat_ready = (st == S_RD);
  assign wr_beat_valid = (st == S_WSEND);
  assign wr_beat_data  = buf_rdata;
  assign buf_we        = (st == S_RD) && rd_beat_valid;
  assign buf_en        = buf_we || (st == S_WFETCH);
  assign buf_addr      = bptr;
  assign buf_wdata     = rd_beat_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      is_wr      <= 1'b0;
      done_q     <= 1'b0;
      tmo_flag   <= 1'b0;
      cur_addr   <= '0;
      rem        <= '0;
      burst_left <= '0;
      bptr       <= '0;
      tmo        <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          is_wr    <= req_write;
          cur_addr <= req_addr;
          rem      <= req_beats;
          bptr     <= req_buf_addr;
          tmo      <= '0;
          if (req_beats == '0) done_q <= 1'b1;
          else st <= S_CMD;
        end
        S_CMD: if (ack_match) begin
          burst_left <= burst_sz;
          rem        <= rem - REM_W'(burst_sz);
          cur_addr   <= cur_addr + (ADDR_W'(burst_sz) << SHIFT);
          tmo        <= '0;
          st         <= is_wr ? S_WFETCH : S_RD;
        end else if (tmo == TMO_W'(ACK_TIMEOUT - 1)) begin
          tmo_flag <= 1'b1;
          st       <= S_IDLE;
        end else begin
          tmo <= tmo + 1'b1;
        end
        S_WFETCH: st <= S_WSEND;
        S_RD, S_WSEND: if (beat_taken) begin
          bptr       <= bptr + 1'b1;
          burst_left <= burst_left - 1'b1;
          if (burst_left == BEAT_W'(1)) begin
            if (rem == '0) begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              st <= S_CMD;
            end
          end else if (st == S_WSEND) begin
            st <= S_WFETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ack_match && tmo != TMO_W'(ACK_TIMEOUT - 1)) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_beats))); // R2
  AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (!buf_en && !wr_beat_valid)); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> (buf_addr == BUF_AW'($past(buf_addr) + 1'b1))); // R3
  AST_BURST_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_beats != '0 && cmd_beats <= BEAT_W'(MAX_BEATS))); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R6
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_timeout |=> ack_timeout); // R7
endmodule

// File: tb/tb_burst_xfer_engine.sv
module tb_burst_xfer_engine;
  localparam int CLK_P = 10;
  localparam int AW = 32, DW = 32, BAW = 6, LW = 20, MB = 256, TMO = 16;
  localparam int DEPTH = 1 << BAW;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [BAW-1:0] req_buf_addr = '0;
  logic req_ready, done, ack_timeout, cmd_valid, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [8:0] cmd_beats;
  logic mem_rd_rdy = 0, mem_wr_rdy = 0, rd_beat_valid = 0, wr_beat_ready = 0;
  logic [DW-1:0] rd_beat_data = '0;
  logic rd_beat_ready, wr_beat_valid, buf_en, buf_we;
  logic [DW-1:0] wr_beat_data, buf_wdata, buf_rdata;
  logic [BAW-1:0] buf_addr;

  logic [DW-1:0] ram [0:DEPTH-1];
  logic [DW-1:0] shadow [0:DEPTH-1];
  int exp_a[$];
  logic [DW-1:0] exp_d[$];
  int errs = 0, checks = 0;

  burst_xfer_engine #(.ADDR_W(AW), .DATA_W(DW), .BUF_AW(BAW), .LEN_W(LW),
                      .MAX_BEATS(MB), .ACK_TIMEOUT(TMO)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk)
    if (buf_en) begin
      if (buf_we) ram[buf_addr] <= buf_wdata;
      else buf_rdata <= ram[buf_addr];
    end

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin : buf_mon
    int a;
    logic [DW-1:0] d;
    if (rst_n && buf_we) begin
      if (exp_a.size() == 0) chk(0, "R9", "unexpected buffer write", buf_addr, 0);
      else begin
        a = exp_a.pop_front();
        d = exp_d.pop_front();
        chk(buf_addr == BAW'(a), "R3", "buffer write location", buf_addr, a);
        chk(buf_wdata == d, "R3", "buffer write data", buf_wdata, d);
      end
    end
  end

  task automatic wait_cmd;
    for (int n = 0; n < 40 && !cmd_valid; n++) step;
    chk(cmd_valid, "R2", "command raised", cmd_valid, 1);
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] addr, input int len, input int baddr);
    req_valid = 1; req_write = wr; req_addr = addr; req_len = LW'(len); req_buf_addr = BAW'(baddr);
    chk(req_ready == 1, "R1", "ready before request", req_ready, 1);
    step;
    req_valid = 0;
  endtask

  task automatic finish_xfer;
    chk(done == 1, "R6", "done after final beat", done, 1);
    step;
    chk(done == 0, "R6", "done lasts one cycle", done, 0);
    chk(req_ready == 1, "R1", "idle after completion", req_ready, 1);
  endtask

  task automatic run_read(input logic [AW-1:0] addr, input int len, input int baddr, input int ackd, input bit poke);
    int left = (len + 3) / 4;
    logic [AW-1:0] a = addr;
    int b = baddr;
    logic [DW-1:0] d;
    issue(0, addr, len, baddr);
    while (left > 0) begin
      int bs = (left > MB) ? MB : left;
      wait_cmd;
      chk(cmd_addr == a, "R4", "read burst address", cmd_addr, a);
      chk(cmd_beats == 9'(bs), "R4", "read burst beats", cmd_beats, bs);
      chk(cmd_write == 0, "R2", "read command direction", cmd_write, 0);
      mem_wr_rdy = 1; rd_beat_valid = 1; rd_beat_data = 32'hDEAD0000;
      @(negedge clk);
      chk(!buf_we, "R9", "stray beat while command pending", buf_we, 0);
      @(posedge clk); #1;
      mem_wr_rdy = 0; rd_beat_valid = 0;
      chk(cmd_valid == 1, "R2", "wrong acknowledgment ignored", cmd_valid, 1);
      repeat (ackd) step;
      mem_rd_rdy = 1; step; mem_rd_rdy = 0;
      for (int k = 0; k < bs; k++) begin
        if (k % 5 == 2) begin rd_beat_valid = 0; step; end
        d = addr ^ (32'h01010101 * k) ^ 32'(b) ^ 32'(left << 12);
        exp_a.push_back(b); exp_d.push_back(d); shadow[b] = d;
        rd_beat_valid = 1; rd_beat_data = d;
        if (poke && k == 0) begin
          req_valid = 1; req_write = 1;
          chk(req_ready == 0, "R1", "busy refuses request", req_ready, 0);
        end
        step;
        req_valid = 0;
        b = (b + 1) % DEPTH;
      end
      rd_beat_valid = 0;
      left -= bs; a += AW'(bs * 4);
      if (left > 0) chk(done == 0, "R6", "no done between bursts", done, 0);
    end
    finish_xfer;
    if (poke) begin
      repeat (3) begin
        chk(cmd_valid == 0, "R1", "refused request left no command", cmd_valid, 0);
        step;
      end
    end
  endtask

  task automatic run_write(input logic [AW-1:0] addr, input int len, input int baddr, input int ackd);
    int left = (len + 3) / 4;
    logic [AW-1:0] a = addr;
    int b = baddr;
    logic [DW-1:0] hold;
    issue(1, addr, len, baddr);
    while (left > 0) begin
      int bs = (left > MB) ? MB : left;
      wait_cmd;
      chk(cmd_addr == a, "R4", "write burst address", cmd_addr, a);
      chk(cmd_beats == 9'(bs), "R4", "write burst beats", cmd_beats, bs);
      chk(cmd_write == 1, "R2", "write command direction", cmd_write, 1);
      mem_rd_rdy = 1; step; mem_rd_rdy = 0;
      chk(cmd_valid == 1, "R2", "wrong acknowledgment ignored", cmd_valid, 1);
      repeat (ackd) step;
      mem_wr_rdy = 1; step; mem_wr_rdy = 0;
      for (int k = 0; k < bs; k++) begin
        for (int n = 0; n < 10 && !wr_beat_valid; n++) step;
        chk(wr_beat_valid, "R5", "write beat offered", wr_beat_valid, 1);
        if (k % 4 == 1) begin
          hold = wr_beat_data;
          step; step;
          chk(wr_beat_valid && wr_beat_data == hold, "R5", "beat held without ready", wr_beat_data, hold);
        end
        chk(wr_beat_data == shadow[b], "R5", "write beat data", wr_beat_data, shadow[b]);
        wr_beat_ready = 1; step; wr_beat_ready = 0;
        b = (b + 1) % DEPTH;
      end
      left -= bs; a += AW'(bs * 4);
      if (left > 0) chk(done == 0, "R6", "no done between bursts", done, 0);
    end
    finish_xfer;
  endtask

  task automatic run_timeout;
    int n = 0;
    bit saw_done = 0;
    issue(0, 32'h3000, 8, 0);
    while (cmd_valid && n < 100) begin
      n++;
      if (done) saw_done = 1;
      step;
    end
    chk(n == TMO, "R7", "command lifetime before timeout", n, TMO);
    chk(ack_timeout == 1, "R7", "timeout flag set", ack_timeout, 1);
    chk(req_ready == 1 && !saw_done && !done, "R7", "idle without done", done, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++;
    $display("FAIL R6 watchdog: actual=hung expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ram[i] = 32'hA5000000 + 32'(i * 7);
      shadow[i] = ram[i];
    end
    repeat (3) step;
    chk(req_ready == 1, "R8", "reset ready", req_ready, 1);
    chk(cmd_valid == 0, "R8", "reset command", cmd_valid, 0);
    chk(done == 0, "R8", "reset done", done, 0);
    chk(ack_timeout == 0, "R8", "reset timeout flag", ack_timeout, 0);
    chk(buf_en == 0, "R8", "reset buffer enable", buf_en, 0);
    rst_n = 1;
    step;
    rd_beat_valid = 1; rd_beat_data = 32'h0BAD0BAD;
    @(negedge clk);
    chk(!buf_we, "R9", "stray beat while idle", buf_we, 0);
    @(posedge clk); #1;
    rd_beat_valid = 0;

    run_write(32'h0000_4000, 40, 60, 2);
    run_read(32'h0000_1000, 22, 5, 0, 0);
    issue(0, 32'h5000, 0, 0);
    chk(done == 1 && cmd_valid == 0, "R6", "zero length completes at once", done, 1);
    step;
    chk(done == 0 && cmd_valid == 0, "R6", "zero length issues no command", cmd_valid, 0);
    run_read(32'h0000_2000, 1100, 10, 3, 1);
    run_write(32'h0000_8000, 1100, 10, 1);
    run_timeout;
    run_read(32'h0000_6000, 4, 33, 1, 0);
    chk(ack_timeout == 1, "R7", "timeout flag sticky", ack_timeout, 1);
    chk(exp_a.size() == 0, "R3", "all expected buffer writes seen", exp_a.size(), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule